// File: doc/BRIEF.md
# Chip-Select Configuration and Decode Unit

This unit sits between an embedded bus master and a static-memory bus timing engine. It keeps two 32-bit configuration words. One byte in them describes each of six external memory regions: a clock-output enable, a sequential-access enable, a 4-bit wait-state code and a 2-bit width code. On every bus access it looks at the top address nibble and drives one of eight active-low selects. It also presents the effective settings of the addressed region, so the timing engine can act on them in the same cycle.

Two selects serve on-chip memories: select 6 is the local SRAM and select 7 is the boot ROM. Their settings are fixed, and writes to their fields have no effect. Two card-interface enable inputs can take over the regions of selects 4 and 5. When a region is taken over, its chip select stays inactive and a card-request line is raised instead. Two strap pins are captured during power-on reset. They give the boot ROM width, and that width changes how every programmed width code is read.

Top module: `csel_unit`

## Requirements
- R1: With `bus_req` high and `bus_addr_hi[3]` low, exactly `cs_n[bus_addr_hi[2:0]]` is driven low. With `bus_req` low, or with `bus_addr_hi[3]` high, all eight selects are high.
- R2: With `cfg_sel`=0, the read data is word A. Select k's byte sits at bits 8k+7:8k, for k=0..3. With `cfg_sel`=1, the read data is word B: select 4 in bits 7:0, select 5 in bits 15:8, the fixed SRAM byte 8'h00 in bits 23:16 and the fixed ROM byte 8'h02 in bits 31:24. Read data is combinational.
- R3: A one-cycle `cfg_we` stores `cfg_wdata` into the word chosen by `cfg_sel`. The new value is readable from the next cycle on. Bits 31:16 of a write to word B are discarded.
- R4: For an enabled programmable region, the configuration byte gives the outputs as follows: bit 7 drives `eff_clken`, bit 6 drives `eff_seqen`, bits 5:2 drive `eff_wait`, and bits 1:0 are the width code.
- R5: `eff_width` is encoded 0=32-bit, 1=16-bit, 2=8-bit. The boot width B is taken from the boot bits: 01 means 8-bit, 10 means 16-bit, and 00 or 11 means 32-bit. If B is 32-bit, width codes 00/01/10/11 give 32/16/8/32. Otherwise code 00 gives B, the code that would normally give B gives 32, and the other codes keep their normal meaning.
- R6: An access to select 6 always gives width 32 (0), wait 0 and both enables 0, whatever was written.
- R7: An access to select 7 always gives width 8 (2), wait 0 and both enables 0, whatever was written.
- R8: While `card_en[k]` is high (k=0,1), an access to the region of select 4+k keeps every `cs_n` bit high, raises `card_req[k]` and drives all `eff_*` outputs to 0. While `card_en[k]` is low, that region behaves as a normal programmable region and `card_req[k]` stays low.
- R9: A low `rst_n` clears every programmable bit in both words. After release, word A reads 0 and word B reads 32'h0200_0000. The boot bits are not changed.
- R10: `boot_bits` takes the value of `strap` on each clock edge while `por_n` is low. It holds that value after `por_n` rises, however `strap` changes. `por_n` low also clears the programmable bits.
- R11: When no chip select is active, all `eff_*` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| por_n | input | 1 | Synchronous power-on reset, active low |
| strap | input | 2 | Boot-width strap pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 = word A, 1 = word B |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| card_en | input | 2 | Card-interface enables for selects 4 and 5 |
| bus_req | input | 1 | Bus access valid |
| bus_addr_hi | input | 4 | Bus address bits 31:28 |
| cs_n | output | 8 | Active-low chip selects |
| card_req | output | 2 | Card-interface request for regions 4 and 5 |
| eff_wait | output | 4 | Effective wait-state code |
| eff_width | output | 2 | Effective bus width (0=32, 1=16, 2=8) |
| eff_clken | output | 1 | Effective clock-output enable |
| eff_seqen | output | 1 | Effective sequential-access enable |
| boot_bits | output | 2 | Captured boot-width bits |

## Verification
Outputs are combinational from the stored bytes, so a corrupted configuration byte shows up on `cfg_rdata` and on the `eff_*` outputs in the same cycle that region is addressed. A wrongly captured strap shows up as a changed `eff_width` for codes 00 and for the code matching the boot width, and never anywhere else. That is why the bench checks widths under every boot value. A bad override or decode appears at once as two active selects, or as a select that fires together with `card_req`.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int EXT_N     = 6;
  localparam int FLD_W     = 8;
  localparam int REGION_W  = 3;
  localparam int SEL_N     = 1 << REGION_W;
  localparam int CARD_N    = 2;
  localparam int CARD_BASE = 4;
  localparam int SRAM_IDX  = 6;
  localparam int ROM_IDX   = 7;

  localparam logic [1:0] W32 = 2'd0;
  localparam logic [1:0] W16 = 2'd1;
  localparam logic [1:0] W8  = 2'd2;

  typedef struct packed {
    logic       clk_en;
    logic       seq_en;
    logic [3:0] wait_c;
    logic [1:0] wcode;
  } sel_cfg_t;

  localparam sel_cfg_t FIX_SRAM = '{clk_en: 1'b0, seq_en: 1'b0, wait_c: 4'd0, wcode: 2'b00};
  localparam sel_cfg_t FIX_ROM  = '{clk_en: 1'b0, seq_en: 1'b0, wait_c: 4'd0, wcode: 2'b10};

  function automatic logic [1:0] boot_width(input logic [1:0] b);
    case (b)
      2'b01:   return W8;
      2'b10:   return W16;
      default: return W32;
    endcase
  endfunction

  function automatic logic [1:0] plain_width(input logic [1:0] c);
    case (c)
      2'b01:   return W16;
      2'b10:   return W8;
      default: return W32;
    endcase
  endfunction

  function automatic logic [1:0] mapped_width(input logic [1:0] c, input logic [1:0] b);
    logic [1:0] bw;
    bw = boot_width(b);
    if (bw == W32)              return plain_width(c);
    if (c == 2'b00)             return bw;
    if (plain_width(c) == bw)   return W32;
    return plain_width(c);
  endfunction
endpackage

// File: rtl/csel_strap.sv
module csel_strap #(
  parameter int BOOT_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [BOOT_W-1:0] strap,
  output logic [BOOT_W-1:0] boot_q
);
  always_ff @(posedge clk) begin
    if (!por_n) boot_q <= strap;
  end
endmodule

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   clr,
  input  logic                   we,
  input  logic                   sel,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  output logic [EXT_N*FLD_W-1:0] fld_o
);
  localparam int BYTES_PER_WORD = WORD_W / FLD_W;
  localparam int SLOT_N         = 2 * BYTES_PER_WORD;

  logic [FLD_W-1:0]        fld_q [EXT_N];
  logic [SLOT_N*FLD_W-1:0] slots;

  always_ff @(posedge clk) begin
    for (int i = 0; i < EXT_N; i++) begin
      if (clr)
        fld_q[i] <= '0;
      else if (we && (sel == 1'(i / BYTES_PER_WORD)))
        fld_q[i] <= wdata[(i % BYTES_PER_WORD)*FLD_W +: FLD_W];
    end
  end

  generate
    for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      if (s < EXT_N) begin : g_prog
        assign slots[s*FLD_W +: FLD_W] = fld_q[s];
        assign fld_o[s*FLD_W +: FLD_W] = fld_q[s];
      end else if (s == SRAM_IDX) begin : g_sram
        assign slots[s*FLD_W +: FLD_W] = FIX_SRAM;
      end else begin : g_rom
        assign slots[s*FLD_W +: FLD_W] = FIX_ROM;
      end
    end
  endgenerate

  assign rdata = sel ? slots[2*WORD_W-1 -: WORD_W] : slots[WORD_W-1:0];
endmodule

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic                bus_req,
  input  logic [REGION_W:0]   addr_hi,
  input  logic [CARD_N-1:0]   card_en,
  output logic                region_hit,
  output logic [REGION_W-1:0] region_idx,
  output logic [CARD_N-1:0]   card_owned,
  output logic [SEL_N-1:0]    cs_n,
  output logic [CARD_N-1:0]   card_req
);
  assign region_hit = bus_req && !addr_hi[REGION_W];
  assign region_idx = addr_hi[REGION_W-1:0];

  generate
    for (genvar k = 0; k < CARD_N; k++) begin : g_card
      assign card_owned[k] = region_hit && card_en[k] &&
                             (region_idx == REGION_W'(CARD_BASE + k));
      assign card_req[k]   = card_owned[k];
    end
    for (genvar s = 0; s < SEL_N; s++) begin : g_cs
      assign cs_n[s] = !(region_hit && (region_idx == REGION_W'(s)) && !(|card_owned));
    end
  endgenerate
endmodule

// File: rtl/csel_cfgmux.sv
module csel_cfgmux
  import csel_pkg::*;
(
  input  logic                   region_hit,
  input  logic [REGION_W-1:0]    region_idx,
  input  logic                   card_any,
  input  logic [EXT_N*FLD_W-1:0] fld,
  input  logic [1:0]             boot,
  output sel_cfg_t               eff
);
  localparam logic [REGION_W-1:0] EXT_LIM = REGION_W'(EXT_N);
  localparam logic [REGION_W-1:0] SRAM_I  = REGION_W'(SRAM_IDX);

  sel_cfg_t raw;

  always_comb begin
    eff = '0;
    raw = '0;
    if (region_hit && !card_any) begin
      if (region_idx < EXT_LIM) begin
        raw       = fld[region_idx*FLD_W +: FLD_W];
        eff       = raw;
        eff.wcode = mapped_width(raw.wcode, boot);
      end else if (region_idx == SRAM_I) begin
        eff       = FIX_SRAM;
        eff.wcode = W32;
      end else begin
        eff       = FIX_ROM;
        eff.wcode = W8;
      end
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [1:0]        strap,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [1:0]        card_en,
  input  logic              bus_req,
  input  logic [3:0]        bus_addr_hi,
  output logic [7:0]        cs_n,
  output logic [1:0]        card_req,
  output logic [3:0]        eff_wait,
  output logic [1:0]        eff_width,
  output logic              eff_clken,
  output logic              eff_seqen,
  output logic [1:0]        boot_bits
);
  logic                   sys_clr;
  logic                   region_hit;
  logic [REGION_W-1:0]    region_idx;
  logic [CARD_N-1:0]      card_owned;
  logic [EXT_N*FLD_W-1:0] fld;
  sel_cfg_t               eff;

  assign sys_clr = !rst_n || !por_n;

  csel_strap #(.BOOT_W(2)) u_strap (
    .clk    (clk),
    .por_n  (por_n),
    .strap  (strap),
    .boot_q (boot_bits)
  );

  csel_regs #(.WORD_W(WORD_W)) u_regs (
    .clk   (clk),
    .clr   (sys_clr),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .fld_o (fld)
  );

  csel_decode u_dec (
    .bus_req    (bus_req),
    .addr_hi    (bus_addr_hi),
    .card_en    (card_en),
    .region_hit (region_hit),
    .region_idx (region_idx),
    .card_owned (card_owned),
    .cs_n       (cs_n),
    .card_req   (card_req)
  );

  csel_cfgmux u_mux (
    .region_hit (region_hit),
    .region_idx (region_idx),
    .card_any   (|card_owned),
    .fld        (fld),
    .boot       (boot_bits),
    .eff        (eff)
  );

  assign eff_wait  = eff.wait_c;
  assign eff_width = eff.wcode;
  assign eff_clken = eff.clk_en;
  assign eff_seqen = eff.seq_en;
endmodule

// File: rtl/csel_chk.sv
module csel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        por_n,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic [1:0]  card_en,
  input logic        bus_req,
  input logic [3:0]  bus_addr_hi,
  input logic [7:0]  cs_n,
  input logic [1:0]  card_req,
  input logic [3:0]  eff_wait,
  input logic [1:0]  eff_width,
  input logic        eff_clken,
  input logic        eff_seqen,
  input logic [1:0]  boot_bits
);
  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0(~cs_n));
  // R1
  unmapped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!bus_req || bus_addr_hi[3]) |-> (cs_n == 8'hFF && card_req == 2'b00));
  // R2
  fixed_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    cfg_sel |-> (cfg_rdata[31:16] == 16'h0200));
  // R3
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cfg_we && !cfg_sel) |=> (cfg_sel || cfg_rdata == $past(cfg_wdata)));
  // R6
  sram_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !cs_n[6] |-> (eff_width == 2'd0 && eff_wait == 4'd0 && !eff_clken && !eff_seqen));
  // R7
  rom_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !cs_n[7] |-> (eff_width == 2'd2 && eff_wait == 4'd0 && !eff_clken && !eff_seqen));
  // R8
  card_own_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (|card_req) |-> (cs_n == 8'hFF && eff_wait == 4'd0 && !eff_clken && !eff_seqen));
  // R8
  card_norm_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_req && bus_addr_hi == 4'd4 && !card_en[0]) |-> (!cs_n[4] && !card_req[0]));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rst_n) && !cfg_sel) |-> (cfg_rdata == 32'h0));
  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> $stable(boot_bits));
  // R11
  idle_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cs_n == 8'hFF) |-> (eff_wait == 4'd0 && eff_width == 2'd0 && !eff_clken && !eff_seqen));
endmodule

bind csel_unit csel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_n       (por_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .card_en     (card_en),
  .bus_req     (bus_req),
  .bus_addr_hi (bus_addr_hi),
  .cs_n        (cs_n),
  .card_req    (card_req),
  .eff_wait    (eff_wait),
  .eff_width   (eff_width),
  .eff_clken   (eff_clken),
  .eff_seqen   (eff_seqen),
  .boot_bits   (boot_bits)
);

// File: tb/tb_csel_unit.sv
`timescale 1ns/1ps
module tb_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic [1:0]  strap;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [1:0]  card_en, card_req, eff_width, boot_bits;
  logic        bus_req, eff_clken, eff_seqen;
  logic [3:0]  bus_addr_hi, eff_wait;
  logic [7:0]  cs_n;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  csel_unit dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .strap(strap),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .card_en(card_en), .bus_req(bus_req), .bus_addr_hi(bus_addr_hi),
    .cs_n(cs_n), .card_req(card_req), .eff_wait(eff_wait), .eff_width(eff_width),
    .eff_clken(eff_clken), .eff_seqen(eff_seqen), .boot_bits(boot_bits)
  );

  // {card_en, bus_req, addr_hi, exp cs_n, exp card_req, exp {clk,seq,wait,width}}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {2'b00, 1'b1, 4'h0, 8'hFE, 2'b00, 8'h87 & 8'hFC},  // R1 R4 R5 sel0 code 11 -> 32
    {2'b00, 1'b1, 4'h1, 8'hFD, 2'b00, 8'h4A},          // R4 sel1 code 10 -> 8
    {2'b00, 1'b1, 4'h2, 8'hFB, 2'b00, 8'h3D},          // R4 sel2 code 01 -> 16
    {2'b00, 1'b1, 4'h3, 8'hF7, 2'b00, 8'hC0},          // R4 sel3
    {2'b00, 1'b1, 4'h4, 8'hEF, 2'b00, 8'h24},          // R4 sel4
    {2'b00, 1'b1, 4'h5, 8'hDF, 2'b00, 8'h96},          // R4 sel5
    {2'b00, 1'b1, 4'h6, 8'hBF, 2'b00, 8'h00},          // R6 sram
    {2'b00, 1'b1, 4'h7, 8'h7F, 2'b00, 8'h02},          // R7 rom
    {2'b00, 1'b1, 4'h8, 8'hFF, 2'b00, 8'h00},          // R1 R11 upper half
    {2'b00, 1'b0, 4'h1, 8'hFF, 2'b00, 8'h00},          // R1 R11 no request
    {2'b01, 1'b1, 4'h4, 8'hFF, 2'b01, 8'h00},          // R8 card 0 owns sel4
    {2'b10, 1'b1, 4'h5, 8'hFF, 2'b10, 8'h00},          // R8 card 1 owns sel5
    {2'b10, 1'b1, 4'h4, 8'hEF, 2'b00, 8'h24},          // R8 sel4 normal
    {2'b01, 1'b1, 4'h5, 8'hDF, 2'b00, 8'h96},          // R8 sel5 normal
    {2'b11, 1'b1, 4'h2, 8'hFB, 2'b00, 8'h3D}           // R8 other region unaffected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_all();
    wr(1'b0, 32'hC03D4A87);
    wr(1'b1, 32'hFFFF9624);
  endtask

  task automatic power_on(input logic [1:0] s);
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0; strap = s;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1; strap = ~s;
  endtask

  task automatic access(input logic [3:0] a);
    @(negedge clk);
    card_en = 2'b00; bus_req = 1'b1; bus_addr_hi = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; card_en = 0; bus_req = 0; bus_addr_hi = 0;
    rst_n = 0; por_n = 0; strap = 2'b00;
    power_on(2'b00);
    @(negedge clk); #1;
    // reset state
    cfg_sel = 1'b0; #1;
    chk("R9 word A after reset", cfg_rdata, 32'h0);
    cfg_sel = 1'b1; #1;
    chk("R2 word B after reset", cfg_rdata, 32'h02000000);
    chk("R1 selects idle", {24'h0, cs_n}, 32'hFF);
    chk("R10 boot bits captured", {30'h0, boot_bits}, 32'h0);

    program_all();
    cfg_sel = 1'b0; #1;
    chk("R2 R3 word A readback", cfg_rdata, 32'hC03D4A87);
    cfg_sel = 1'b1; #1;
    chk("R3 R6 R7 word B upper discarded", cfg_rdata, 32'h02009624);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      card_en = VEC[i][24:23]; bus_req = VEC[i][22]; bus_addr_hi = VEC[i][21:18];
      #1;
      chk("R1 R8 cs_n vector", {24'h0, cs_n}, {24'h0, VEC[i][17:10]});
      chk("R8 card_req vector", {30'h0, card_req}, {30'h0, VEC[i][9:8]});
      chk("R4 R5 R11 eff vector", {24'h0, eff_clken, eff_seqen, eff_wait, eff_width},
          {24'h0, VEC[i][7:0]});
    end

    // R9: system reset clears, boot bits kept
    @(negedge clk);
    bus_req = 0; rst_n = 1'b0; strap = 2'b11;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    cfg_sel = 1'b0; #1;
    chk("R9 word A cleared", cfg_rdata, 32'h0);
    cfg_sel = 1'b1; #1;
    chk("R9 word B fixed kept", cfg_rdata, 32'h02000000);
    chk("R9 R10 boot bits unchanged", {30'h0, boot_bits}, 32'h0);
    access(4'h7);
    chk("R7 rom width after reset", {30'h0, eff_width}, 32'd2);

    // R5 boot = 01 (8-bit)
    power_on(2'b01);
    program_all();
    chk("R10 boot bits 01 held", {30'h0, boot_bits}, 32'd1);
    access(4'h3); chk("R5 boot01 code00 -> 8", {30'h0, eff_width}, 32'd2);
    access(4'h1); chk("R5 boot01 code10 -> 32", {30'h0, eff_width}, 32'd0);
    access(4'h2); chk("R5 boot01 code01 -> 16", {30'h0, eff_width}, 32'd1);
    access(4'h0); chk("R5 boot01 code11 -> 32", {30'h0, eff_width}, 32'd0);
    access(4'h6); chk("R6 sram width under boot01", {30'h0, eff_width}, 32'd0);

    // R5 boot = 10 (16-bit)
    power_on(2'b10);
    program_all();
    chk("R10 boot bits 10 held", {30'h0, boot_bits}, 32'd2);
    access(4'h3); chk("R5 boot10 code00 -> 16", {30'h0, eff_width}, 32'd1);
    access(4'h2); chk("R5 boot10 code01 -> 32", {30'h0, eff_width}, 32'd0);
    access(4'h1); chk("R5 boot10 code10 -> 8", {30'h0, eff_width}, 32'd2);
    access(4'h7); chk("R7 rom width under boot10", {30'h0, eff_width}, 32'd2);

    // R5 boot = 11 behaves as 32-bit boot
    power_on(2'b11);
    program_all();
    access(4'h3); chk("R5 boot11 code00 -> 32", {30'h0, eff_width}, 32'd0);
    access(4'h1); chk("R5 boot11 code10 -> 8", {30'h0, eff_width}, 32'd2);

    // R6: attempt to alter fixed fields, sram still fixed
    wr(1'b1, 32'hFFFF0000);
    access(4'h6);
    chk("R6 sram eff after write", {24'h0, eff_clken, eff_seqen, eff_wait, eff_width}, 32'h0);
    chk("R3 word B low bytes rewritten", {16'h0, cfg_rdata[15:0]}, 32'h0);

    @(negedge clk); bus_req = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule